// File: doc/BRIEF.md
# Cartridge PRG Upper-Address Mapper

This block forms the seven upper program-memory address bits (byte address bits 19 down to 13) for every CPU read or write in the upper 32 kB of the CPU map. A 3-bit mode chooses how those bits are assembled. The sources are a 6-bit outer bank held by the cartridge's configuration logic, six inner bank bits from a separate banking controller, a 3-bit software-written latch, and CPU address lines A14 and A13. The seven bits reach up to 1 MB of program memory.

Three modes hand a shrinking inner window of 512, 256 or 128 kB to the inner controller. Two modes pin a fixed 16 kB or 32 kB bank. One mode gives a switchable 16 kB page in the lower half and a hard-wired last page in the upper half. The two remaining codes drive the address to zero. The address is computed combinationally and captured in one output register, so it is valid one clock after the inputs are sampled.

Top module: `prg_bank_mapper`

## Requirements
- R1: While `rst` is high at a rising clock edge, `prg_addr_hi` becomes 7'h00 after that edge.
- R2: `prg_addr_hi` changes only at a rising clock edge, and it reflects the inputs sampled at that edge. It has one cycle of latency and holds its value between edges.
- R3: When `cpu_a15` is 0, the next `prg_addr_hi` is 7'h00 in every mode.
- R4: In mode 3'b000, the output is {outer_bank[5], inner_bank[5:0]}.
- R5: In mode 3'b001, the output is {outer_bank[5:4], inner_bank[4:0]}.
- R6: In mode 3'b010, the output is {outer_bank[5:3], inner_bank[3:0]}.
- R7: In mode 3'b011, the output is {outer_bank[5:0], cpu_a13}. This is a fixed 16 kB bank mirrored across the window.
- R8: In mode 3'b100, the output is {outer_bank[5:1], cpu_a14, cpu_a13}. This is a fixed 32 kB bank.
- R9: In mode 3'b101 with cpu_a14 = 0, the output is {outer_bank[5:3], latch_bank[2:0], cpu_a13}.
- R10: In mode 3'b101 with cpu_a14 = 1, the output is {outer_bank[5:3], 3'b111, cpu_a13}.
- R11: In modes 3'b110 and 3'b111, the output is 7'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_a15 | input | 1 | CPU address bit 15; high selects the program window |
| cpu_a14 | input | 1 | CPU address bit 14 |
| cpu_a13 | input | 1 | CPU address bit 13 |
| prg_mode | input | 3 | Mapping mode code |
| outer_bank | input | 6 | Outer bank; bit 5 is the most significant |
| inner_bank | input | 6 | Inner controller bank bits for address bits 18..13 |
| latch_bank | input | 3 | Switchable 16 kB page number |
| prg_addr_hi | output | 7 | Registered program address bits 19..13 |

## Verification
The block has no state apart from the output register. A wrong split point or a wrong choice of source therefore shows as wrong bits in `prg_addr_hi` on the first edge after the offending inputs are applied, and is gone again on the next edge. The mode-by-window sweep uses outer, inner and latch patterns whose bits differ from one another, so a bit taken from the wrong position shows directly. The latency checks look on both sides of a clock edge, so a stage that is missing or doubled shows up.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

  localparam int OUTER_W = 6;
  localparam int INNER_W = 6;
  localparam int LATCH_W = 3;
  localparam int ADDR_W  = 7;
  localparam int MODE_W  = 3;

  typedef enum logic [MODE_W-1:0] {
    PM_WIN512  = 3'b000,
    PM_WIN256  = 3'b001,
    PM_WIN128  = 3'b010,
    PM_FIX16   = 3'b011,
    PM_FIX32   = 3'b100,
    PM_SWITCH  = 3'b101,
    PM_OFF_A   = 3'b110,
    PM_OFF_B   = 3'b111
  } prg_mode_e;

  typedef logic [ADDR_W-1:0] prg_addr_t;

endpackage

// File: rtl/prg_window_mux.sv
module prg_window_mux
  import prg_map_pkg::*;
(
  input  logic               sel_a15,
  input  logic               sel_a14,
  input  logic               sel_a13,
  input  logic [MODE_W-1:0]  mode,
  input  logic [OUTER_W-1:0] outer,
  input  logic [INNER_W-1:0] inner,
  input  logic [LATCH_W-1:0] page,
  output prg_addr_t          addr_d
);

  localparam int HI = OUTER_W - 1;

  prg_mode_e mode_e;
  prg_addr_t mapped;

  assign mode_e = prg_mode_e'(mode);

  always_comb begin
    mapped = '0;
    unique case (mode_e)
      PM_WIN512: mapped = {outer[HI],      inner[INNER_W-1:0]};
      PM_WIN256: mapped = {outer[HI:HI-1], inner[INNER_W-2:0]};
      PM_WIN128: mapped = {outer[HI:HI-2], inner[INNER_W-3:0]};
      PM_FIX16:  mapped = {outer,          sel_a13};
      PM_FIX32:  mapped = {outer[HI:1],    sel_a14, sel_a13};
      PM_SWITCH: mapped = sel_a14 ? {outer[HI:HI-2], {LATCH_W{1'b1}}, sel_a13}
                                  : {outer[HI:HI-2], page,            sel_a13};
      PM_OFF_A,
      PM_OFF_B:  mapped = '0;
      default:   mapped = '0;
    endcase
  end

  assign addr_d = sel_a15 ? mapped : '0;

endmodule

// File: rtl/prg_addr_stage.sv
module prg_addr_stage #(
  parameter int WIDTH = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) q[gi] <= 1'b0;
      else     q[gi] <= d[gi];
    end
  end

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_a15,
  input  logic               cpu_a14,
  input  logic               cpu_a13,
  input  logic [MODE_W-1:0]  prg_mode,
  input  logic [OUTER_W-1:0] outer_bank,
  input  logic [INNER_W-1:0] inner_bank,
  input  logic [LATCH_W-1:0] latch_bank,
  output logic [ADDR_W-1:0]  prg_addr_hi
);

  prg_addr_t addr_next;

  prg_window_mux u_mux (
    .sel_a15 (cpu_a15),
    .sel_a14 (cpu_a14),
    .sel_a13 (cpu_a13),
    .mode    (prg_mode),
    .outer   (outer_bank),
    .inner   (inner_bank),
    .page    (latch_bank),
    .addr_d  (addr_next)
  );

  prg_addr_stage #(.WIDTH(ADDR_W)) u_stage (
    .clk (clk),
    .rst (rst),
    .d   (addr_next),
    .q   (prg_addr_hi)
  );

  // R3: outside the program window the next address is zero
  a_r3_window_closed: assert property (@(posedge clk) disable iff (rst)
    !cpu_a15 |=> prg_addr_hi == '0);

  // R11: the two dead modes give zero
  a_r11_dead_modes: assert property (@(posedge clk) disable iff (rst)
    (cpu_a15 && prg_mode[2:1] == 2'b11) |=> prg_addr_hi == '0);

  // R10: the upper half of the switchable mode is pinned to page 111
  a_r10_last_page: assert property (@(posedge clk) disable iff (rst)
    (cpu_a15 && prg_mode == 3'b101 && cpu_a14) |=> prg_addr_hi[3:1] == 3'b111);

  // R7: the fixed 16 kB bank follows CPU A13 in its lowest bit
  a_r7_fix16_low: assert property (@(posedge clk) disable iff (rst)
    (cpu_a15 && prg_mode == 3'b011) |=> prg_addr_hi[0] == $past(cpu_a13));

  // R8: the fixed 32 kB bank follows CPU A14/A13 in its lowest two bits
  a_r8_fix32_low: assert property (@(posedge clk) disable iff (rst)
    (cpu_a15 && prg_mode == 3'b100) |=>
      prg_addr_hi[1:0] == {$past(cpu_a14), $past(cpu_a13)});

  // R2: no change between edges; output is stable when inputs held
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    ($stable(prg_mode) && $stable(outer_bank) && $stable(inner_bank) &&
     $stable(latch_bank) && $stable({cpu_a15, cpu_a14, cpu_a13}) && !$past(rst))
      |=> $stable(prg_addr_hi));

endmodule

// File: tb/test_prg_bank_mapper.sv
`timescale 1ns/1ps
module test_prg_bank_mapper;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       a15 = 1'b0, a14 = 1'b0, a13 = 1'b0;
  logic [2:0] mode = 3'b000;
  logic [5:0] outer = '0, inner = '0;
  logic [2:0] latch = '0;
  logic [6:0] addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  prg_bank_mapper i_prg_bank_mapper (
    .clk (clk), .rst (rst),
    .cpu_a15 (a15), .cpu_a14 (a14), .cpu_a13 (a13),
    .prg_mode (mode), .outer_bank (outer), .inner_bank (inner),
    .latch_bank (latch), .prg_addr_hi (addr)
  );

  // {req[4:0], mode[2:0], a15 a14 a13, outer[5:0], inner[5:0], latch[2:0], exp[6:0]}
  localparam int NV = 16;
  localparam logic [32:0] VEC [NV] = '{
    {5'd4,  3'b000, 3'b101, 6'b101101, 6'b110010, 3'b011, 7'h72}, // R4
    {5'd5,  3'b001, 3'b101, 6'b101101, 6'b110010, 3'b011, 7'h52}, // R5
    {5'd6,  3'b010, 3'b101, 6'b101101, 6'b001101, 3'b011, 7'h5D}, // R6
    {5'd7,  3'b011, 3'b101, 6'b101101, 6'b110010, 3'b011, 7'h5B}, // R7
    {5'd7,  3'b011, 3'b110, 6'b101101, 6'b110010, 3'b011, 7'h5A}, // R7
    {5'd8,  3'b100, 3'b110, 6'b101101, 6'b110010, 3'b011, 7'h5A}, // R8
    {5'd8,  3'b100, 3'b101, 6'b101101, 6'b110010, 3'b011, 7'h59}, // R8
    {5'd9,  3'b101, 3'b101, 6'b101101, 6'b110010, 3'b011, 7'h57}, // R9
    {5'd10, 3'b101, 3'b110, 6'b101101, 6'b110010, 3'b011, 7'h5E}, // R10
    {5'd11, 3'b110, 3'b111, 6'b101101, 6'b110010, 3'b011, 7'h00}, // R11
    {5'd11, 3'b111, 3'b100, 6'b101101, 6'b110010, 3'b011, 7'h00}, // R11
    {5'd3,  3'b000, 3'b011, 6'b101101, 6'b110010, 3'b011, 7'h00}, // R3
    {5'd4,  3'b000, 3'b100, 6'b010011, 6'b011110, 3'b110, 7'h1E}, // R4
    {5'd5,  3'b001, 3'b111, 6'b010011, 6'b011110, 3'b110, 7'h3E}, // R5
    {5'd9,  3'b101, 3'b100, 6'b010011, 6'b011110, 3'b110, 7'h2C}, // R9
    {5'd8,  3'b100, 3'b111, 6'b010011, 6'b011110, 3'b110, 7'h27}  // R8
  };

  task automatic check(input int req, input logic [6:0] exp, input string what);
    n_cmp++;
    if (addr !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, addr, exp);
    end
  endtask

  task automatic apply(input logic [2:0] m, input logic [2:0] a,
                       input logic [5:0] o, input logic [5:0] i, input logic [2:0] l);
    @(negedge clk);
    mode = m; {a15, a14, a13} = a; outer = o; inner = i; latch = l;
  endtask

  // model written from the requirement text
  function automatic logic [6:0] model(input logic [2:0] m, input logic [2:0] a,
                                       input logic [5:0] o, input logic [5:0] i,
                                       input logic [2:0] l);
    if (!a[2]) return 7'h00;                               // R3
    case (m)
      3'b000: return {o[5], i};                            // R4
      3'b001: return {o[5:4], i[4:0]};                     // R5
      3'b010: return {o[5:3], i[3:0]};                     // R6
      3'b011: return {o, a[0]};                            // R7
      3'b100: return {o[5:1], a[1], a[0]};                 // R8
      3'b101: return a[1] ? {o[5:3], 3'b111, a[0]}         // R10
                          : {o[5:3], l, a[0]};             // R9
      default: return 7'h00;                               // R11
    endcase
  endfunction

  function automatic int req_of(input logic [2:0] m, input logic [2:0] a);
    if (!a[2]) return 3;
    case (m)
      3'b000: return 4;
      3'b001: return 5;
      3'b010: return 6;
      3'b011: return 7;
      3'b100: return 8;
      3'b101: return a[1] ? 10 : 9;
      default: return 11;
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with busy inputs applied
    mode = 3'b000; {a15, a14, a13} = 3'b111; outer = 6'h3F; inner = 6'h3F;
    repeat (3) @(posedge clk);
    #1 check(1, 7'h00, "reset holds zero");
    @(negedge clk); rst = 1'b0;

    // table walk
    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][27:25], VEC[v][24:22], VEC[v][21:16], VEC[v][15:10], VEC[v][9:7]);
      @(posedge clk); #1;
      check(int'(VEC[v][32:28]), VEC[v][6:0], "table vector");
    end

    // sweep: every mode against all four 8 kB windows, two bit patterns
    for (int p = 0; p < 2; p++) begin
      for (int m = 0; m < 8; m++) begin
        for (int w = 0; w < 4; w++) begin
          logic [5:0] o = p ? 6'b100110 : 6'b011001;
          logic [5:0] i = p ? 6'b010101 : 6'b101010;
          logic [2:0] l = p ? 3'b010 : 3'b101;
          logic [2:0] a = {1'b1, 2'(w)};
          apply(3'(m), a, o, i, l);
          @(posedge clk); #1;
          check(req_of(3'(m), a), model(3'(m), a, o, i, l), "sweep");
        end
      end
    end

    // R3: A15 low in every mode
    for (int m = 0; m < 8; m++) begin
      apply(3'(m), 3'b011, 6'h3F, 6'h3F, 3'h7);
      @(posedge clk); #1;
      check(3, 7'h00, "a15 low");
    end

    // R2: one-cycle latency seen on both sides of the edge
    apply(3'b011, 3'b101, 6'b111111, 6'h00, 3'h0);
    @(posedge clk); #1;
    check(2, 7'h7F, "settled value");
    apply(3'b011, 3'b100, 6'b000001, 6'h00, 3'h0);
    #1 check(2, 7'h7F, "before edge still old");
    @(posedge clk); #1;
    check(2, 7'h02, "after edge new");
    #2 check(2, 7'h02, "held between edges");

    // R1: reset in mid-run
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check(1, 7'h00, "mid-run reset");
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check(2, 7'h02, "resume after reset");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule